// File: doc/BRIEF.md
# Compare and Carry-Keep Adder Unit

This unit is the integer add/compare slice of a 32-bit execution stage. It computes a result in the same cycle for four operations on operands `a` and `b`: signed compare, unsigned compare, add, and reverse-subtract (`b - a`). The compares return the difference `b - a`. The top bit of that difference is corrected so that it gives the true ordering of the two operands, even when the subtraction overflows.

The unit holds a carry flag in a register, with a shadow copy that always follows it. Add and reverse-subtract have two independent controls for this flag. `use_carry` chains the stored carry in as the carry-in. `keep_carry` stops the operation from writing a new carry. The flags change only on a clock edge where `valid` is high. The result output is purely combinational.

Top module: `cmp_carry_alu`

## Requirements
- R1: With opcode 2'b10 (add), `result` equals `a + b + cin` modulo 2^32. `cin` is the stored carry flag when `use_carry` is 1, and 0 otherwise.
- R2: With opcode 2'b11 (reverse-subtract), `result` equals `b + ~a + cin` modulo 2^32. `cin` is the stored carry flag when `use_carry` is 1, and 1 otherwise.
- R3: The carry-out of an add or reverse-subtract is bit 32 of the 33-bit unsigned sum of its two addends and `cin`. On a clock edge with `valid` high and `keep_carry` low, this carry-out is written to both `carry_flag` and `carry_shadow`.
- R4: When `keep_carry` is 1, an add or reverse-subtract still drives its result, but both flags keep their previous values.
- R5: The flags do not change on an edge where `valid` is low, nor on an edge where the opcode is a compare.
- R6: With opcode 2'b00 (signed compare), `result` is `b - a`. When `a[31]` and `b[31]` differ, bit 31 of the result is replaced by `b[31]`.
- R7: With opcode 2'b01 (unsigned compare), `result` is `b - a`. When `a[31]` and `b[31]` differ, bit 31 of the result is replaced by `a[31]`.
- R8: Compares always use a carry-in of 1, and `use_carry` has no effect on the compare result.
- R9: A synchronous active-low reset clears both `carry_flag` and `carry_shadow` to 0. `carry_shadow` always equals `carry_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Operation strobe; allows the flags to update |
| opcode | input | 2 | 00 signed compare, 01 unsigned compare, 10 add, 11 reverse-subtract |
| use_carry | input | 1 | Take the stored carry as carry-in (add/reverse-subtract) |
| keep_carry | input | 1 | Leave the stored carry unchanged |
| a | input | 32 | Operand a (the subtrahend for subtract and compare) |
| b | input | 32 | Operand b |
| result | output | 32 | Combinational result |
| carry_flag | output | 1 | Stored carry flag |
| carry_shadow | output | 1 | Shadow copy of the carry flag |

## Verification
The hardest case to reach is a chained reverse-subtract or add that consumes a carry flag of 1 left by an earlier operation. Before it, there must be no keep, no idle strobe and no compare that would disturb the flag. The stimulus builds such chains on purpose: a directed multi-word add and subtract sequence, followed by random runs in which `use_carry`, `keep_carry`, `valid` and the opcode vary independently. The compare MSB fix-up is driven with operand pairs whose sign bits differ, including the extreme pairs at `0x80000000` and `0x7FFFFFFF`.

// File: rtl/cck_pkg.sv
// Package: shared opcode type for the compare/carry-keep adder unit.
// Assumes a 2-bit opcode field decoded by the top module.
package cck_pkg;
    typedef enum logic [1:0] {
        OP_CMP_S = 2'b00,
        OP_CMP_U = 2'b01,
        OP_ADD   = 2'b10,
        OP_RSUB  = 2'b11
    } cck_op_e;
endpackage

// File: rtl/cck_adder.sv
// Module: cck_adder
// Ripple-free behavioural adder producing a WIDTH-bit sum and carry-out.
// Assumes the caller has already inverted the subtrahend where needed.
module cck_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] wide_sum;

    // Form the extended sum so the top bit is the carry-out.
    always_comb begin
        wide_sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum      = wide_sum[WIDTH-1:0];
        cout     = wide_sum[WIDTH];
    end
endmodule

// File: rtl/cck_cmp_fix.sv
// Module: cck_cmp_fix
// Corrects the MSB of a compare difference so that it reflects true ordering.
// Assumes diff = b - a; the signed form takes b's MSB and the unsigned form
// takes a's MSB when the operand MSBs differ.
module cck_cmp_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             a_msb,
    input  logic             b_msb,
    input  logic             unsigned_mode,
    output logic [WIDTH-1:0] fixed
);
    logic msb_differs;

    // Replace the top bit only when the operand sign bits disagree.
    always_comb begin
        msb_differs = a_msb ^ b_msb;
        fixed       = diff;
        if (msb_differs) begin
            fixed[WIDTH-1] = unsigned_mode ? a_msb : b_msb;
        end
    end
endmodule

// File: rtl/cck_carry_reg.sv
// Module: cck_carry_reg
// Holds the carry flag and its shadow copy.
// Assumes load already folds in valid, the arithmetic opcode and keep.
module cck_carry_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic carry_in,
    output logic flag,
    output logic shadow
);
    // Synchronous reset clears both; a load writes the same value to both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            shadow <= 1'b0;
        end else if (load) begin
            flag   <= carry_in;
            shadow <= carry_in;
        end
    end
endmodule

// File: rtl/cmp_carry_alu.sv
// Module: cmp_carry_alu
// 32-bit compare / add / reverse-subtract unit with a registered carry flag.
// Assumes the result is consumed in the same cycle; flags update on valid.
module cmp_carry_alu
    import cck_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [1:0]       opcode,
    input  logic             use_carry,
    input  logic             keep_carry,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry_flag,
    output logic             carry_shadow
);
    localparam int MSB = WIDTH - 1;

    cck_op_e          op;
    logic             is_cmp;
    logic             is_sub;
    logic [WIDTH-1:0] add_x;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [WIDTH-1:0] cmp_res;
    logic             flag_load;

    // Decode the opcode and select adder operands and carry-in.
    always_comb begin
        op      = cck_op_e'(opcode);
        is_cmp  = (op == OP_CMP_S) || (op == OP_CMP_U);
        is_sub  = is_cmp || (op == OP_RSUB);
        add_x   = is_sub ? ~a : a;
        if (is_cmp) begin
            add_cin = 1'b1;
        end else if (use_carry) begin
            add_cin = carry_flag;
        end else begin
            add_cin = is_sub;
        end
    end

    cck_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (add_x),
        .y    (b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    cck_cmp_fix #(.WIDTH(WIDTH)) u_cmp_fix (
        .diff          (add_sum),
        .a_msb         (a[MSB]),
        .b_msb         (b[MSB]),
        .unsigned_mode (op == OP_CMP_U),
        .fixed         (cmp_res)
    );

    // Pick the compare-corrected or raw sum and form the flag load enable.
    always_comb begin
        result    = is_cmp ? cmp_res : add_sum;
        flag_load = valid && !is_cmp && !keep_carry;
    end

    cck_carry_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (flag_load),
        .carry_in (add_cout),
        .flag     (carry_flag),
        .shadow   (carry_shadow)
    );
endmodule

// File: rtl/cck_checker.sv
// Module: cck_checker
// Property checker for cmp_carry_alu, attached through bind.
module cck_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid,
    input logic [1:0]       opcode,
    input logic             use_carry,
    input logic             keep_carry,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             carry_flag,
    input logic             carry_shadow
);
    logic [WIDTH:0] plain_add;
    assign plain_add = {1'b0, a} + {1'b0, b};

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!carry_flag && !carry_shadow));

    assert_shadow_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        carry_shadow == carry_flag);

    assert_keep_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && keep_carry) |=> $stable(carry_flag));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || !opcode[1]) |=> $stable(carry_flag));

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode == 2'b10 && !use_carry && !keep_carry)
        |=> carry_flag == $past(plain_add[WIDTH]));

    assert_signed_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b00 && (a[WIDTH-1] != b[WIDTH-1])) |-> result[WIDTH-1] == b[WIDTH-1]);

    assert_unsigned_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b01 && (a[WIDTH-1] != b[WIDTH-1])) |-> result[WIDTH-1] == a[WIDTH-1]);
endmodule

bind cmp_carry_alu cck_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (valid),
    .opcode       (opcode),
    .use_carry    (use_carry),
    .keep_carry   (keep_carry),
    .a            (a),
    .b            (b),
    .result       (result),
    .carry_flag   (carry_flag),
    .carry_shadow (carry_shadow)
);

// File: tb/cmp_carry_alu_tb.sv
module cmp_carry_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic        use_carry = 1'b0;
    logic        keep_carry = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        carry_flag;
    logic        carry_shadow;

    int checks = 0;
    int errors = 0;
    bit model_c = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_carry_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode),
        .use_carry(use_carry), .keep_carry(keep_carry), .a(a), .b(b),
        .result(result), .carry_flag(carry_flag), .carry_shadow(carry_shadow)
    );

    function automatic logic [32:0] ref_sum(input logic [1:0] op, input bit uc,
                                            input bit c, input logic [31:0] x,
                                            input logic [31:0] y);
        logic [31:0] p;
        bit          ci;
        p  = (op == 2'b10) ? x : ~x;
        ci = (op[1] == 1'b0) ? 1'b1 : (uc ? c : (op == 2'b11));
        return {1'b0, y} + {1'b0, p} + {32'd0, ci};
    endfunction

    function automatic logic [31:0] ref_result(input logic [1:0] op, input bit uc,
                                               input bit c, input logic [31:0] x,
                                               input logic [31:0] y);
        logic [31:0] r;
        r = ref_sum(op, uc, c, x, y)[31:0];
        if (op == 2'b00 && x[31] != y[31]) r[31] = y[31];
        if (op == 2'b01 && x[31] != y[31]) r[31] = x[31];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'b00: return "R6";
            2'b01: return "R7";
            2'b10: return "R1";
            default: return "R2";
        endcase
    endfunction

    // Apply one operation at the falling edge, check the result, then the flags.
    task automatic do_op(input logic [1:0] op, input bit uc, input bit kp,
                         input bit v, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er;
        logic [32:0] es;
        @(negedge clk);
        opcode = op; use_carry = uc; keep_carry = kp; valid = v; a = x; b = y;
        #1;
        er = ref_result(op, uc, model_c, x, y);
        es = ref_sum(op, uc, model_c, x, y);
        check(result == er, req_of(op), result, er);
        @(posedge clk);
        #1;
        if (v && op[1] && !kp) model_c = es[32];
        // R3 on load, R4 on keep, R5 on idle/compare
        check(carry_flag == model_c,
              (!v || !op[1]) ? "R5" : (kp ? "R4" : "R3"),
              {31'd0, carry_flag}, {31'd0, model_c});
        check(carry_shadow == carry_flag, "R9", {31'd0, carry_shadow}, {31'd0, carry_flag});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check(carry_flag == 1'b0 && carry_shadow == 1'b0, "R9", {31'd0, carry_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: add overflow sets carry; chained add consumes it
        do_op(2'b10, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
        check(carry_flag == 1'b1, "R3", {31'd0, carry_flag}, 32'd1);
        do_op(2'b10, 1, 0, 1, 32'h0000_0000, 32'h0000_0005);
        // R4: keep leaves flag while producing result
        do_op(2'b10, 0, 0, 1, 32'h8000_0000, 32'h8000_0000);
        do_op(2'b10, 0, 1, 1, 32'h0000_0001, 32'h0000_0002);
        // R2: reverse-subtract without borrow and chained
        do_op(2'b11, 0, 0, 1, 32'h0000_0003, 32'h0000_0001);
        do_op(2'b11, 1, 0, 1, 32'h0000_0000, 32'h0000_0000);
        do_op(2'b11, 1, 0, 1, 32'h0000_0001, 32'h0000_0009);
        // R5: valid low and compares leave the flag
        do_op(2'b10, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_op(2'b00, 0, 0, 1, 32'h0000_0001, 32'h0000_0000);
        // R6/R7: sign-differing extremes
        do_op(2'b00, 0, 0, 1, 32'h7FFF_FFFF, 32'h8000_0000);
        do_op(2'b00, 0, 0, 1, 32'h8000_0000, 32'h7FFF_FFFF);
        do_op(2'b01, 0, 0, 1, 32'h7FFF_FFFF, 32'h8000_0000);
        do_op(2'b01, 0, 0, 1, 32'h8000_0000, 32'h7FFF_FFFF);
        // R8: use_carry ignored by compare, with flag set
        do_op(2'b10, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_0002);
        do_op(2'b00, 1, 0, 1, 32'h0000_0005, 32'h0000_0005);
        check(result == 32'd0, "R8", result, 32'd0);
        do_op(2'b01, 1, 0, 1, 32'h0000_0004, 32'h0000_0009);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if ((i % 7) == 0) ra[31] = ~rb[31];
            do_op(2'(($urandom() % 4)), 1'($urandom() % 2), 1'(($urandom() % 4) == 0),
                  1'(($urandom() % 5) != 0), ra, rb);
        end

        // R9: reset mid-run clears a set flag
        do_op(2'b10, 0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0;
        @(posedge clk);
        #1;
        model_c = 1'b0;
        check(carry_flag == 1'b0 && carry_shadow == 1'b0, "R9", {31'd0, carry_flag}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule